// File: doc/BRIEF.md
# Packed-Pixel Colour Expander

This block turns a stream of one-byte packed pixels into 24-bit true-colour words. Each input byte carries three 2-bit colour channels plus a 2-bit modifier field. Every channel is widened to 8 bits. The modifier is not an alpha value or a palette index. It becomes an XOR mask, and that mask changes all three channels in the same way. The result is a cheap colour shift in hardware that needs no storage.

The converter accepts one pixel per clock, each qualified by a valid flag. It delivers the converted pixel exactly two clocks later, with a valid flag delayed to match. A static order input selects which end of the output word holds red and which holds blue, so either display-side byte convention can be served. Between valid pixels the output word keeps its last value, so downstream logic sees no stray toggling.

Top module: `hrgb_expand_top`

## Requirements
- R1: Input bits [5:4] are red, [3:2] are green and [1:0] are blue. A 2-bit channel value C is first widened to the 4-bit value {C, C}.
- R2: The modifier field is input bits [7:6]. It forms a 4-bit mask {0, bit7, bit6, 0}. That same mask is XORed into the 4-bit widened red, green and blue values.
- R3: The 4-bit result after the XOR is copied into both nibbles of the 8-bit channel value, so the upper nibble of every output byte equals its lower nibble.
- R4: With order_bgr = 0, red is out_rgb[7:0], green is out_rgb[15:8] and blue is out_rgb[23:16].
- R5: With order_bgr = 1, blue is out_rgb[7:0], green is out_rgb[15:8] and red is out_rgb[23:16].
- R6: The latency is two clocks. out_valid equals in_valid from two rising edges earlier, and a pixel presented with in_valid high appears on out_rgb two edges later.
- R7: A low rst_n at a rising edge clears out_valid and out_rgb to zero. This applies both at start-up and in the middle of a stream.
- R8: While out_valid is low, out_rgb holds the value of the last valid pixel, or zero if there has been no valid pixel since reset. Input bytes presented with in_valid low have no effect on it.
- R9: With a modifier of 0, the channel values 0, 1, 2 and 3 become 0x00, 0x55, 0xAA and 0xFF. With input 0xFF every channel becomes 0x99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies in_pixel in this cycle |
| in_pixel | input | 8 | Packed pixel: modifier, red, green, blue |
| order_bgr | input | 1 | 0: red in low byte; 1: blue in low byte |
| out_valid | output | 1 | Qualifies out_rgb, two cycles after in_valid |
| out_rgb | output | 24 | Expanded colour word |

## Verification
The assertions assume that order_bgr does not change while a pixel is inside the pipeline. The byte-placement checks compare out_rgb against the stage-one channels of the previous cycle, and that comparison is only valid if the mode is the same at both ends. The stimulus therefore changes the mode only after at least three idle cycles have emptied the pipeline. The stimulus also holds reset for several cycles at start-up, so that the assertions never compare against values from before reset. All other input patterns are left free: any byte, any valid pattern and reset in the middle of a stream.

// File: rtl/hrgb_pkg.sv
// Package: shared widths and types for the packed-pixel colour expander.
// Assumes the packed byte holds three equal colour fields plus one
// modifier field of the same width, located in the top bits.
package hrgb_pkg;
    localparam int CH_W    = 2;              // bits per packed colour field
    localparam int NUM_CH  = 3;              // blue, green, red
    localparam int NIB_W   = 2 * CH_W;       // widened field
    localparam int BYTE_W  = 2 * NIB_W;      // final channel width
    localparam int PIX_W   = (NUM_CH + 1) * CH_W;
    localparam int WORD_W  = NUM_CH * BYTE_W;

    // Channel index matches the field position inside the packed byte.
    localparam int IDX_B = 0;
    localparam int IDX_G = 1;
    localparam int IDX_R = 2;

    typedef logic [BYTE_W-1:0] chan8_t;
    typedef chan8_t [NUM_CH-1:0] chan_set_t;
endpackage

// File: rtl/hrgb_chan_widen.sv
// Module: hrgb_chan_widen
// Widens one colour field: self-concatenation to a nibble, XOR with the
// mask built from the modifier field, then the nibble is copied into both
// halves of the output byte. Purely combinational.
// Assumes the modifier field has the same width as a colour field.
module hrgb_chan_widen
    import hrgb_pkg::*;
#(
    parameter int CW = CH_W
) (
    input  logic [CW-1:0]   code,
    input  logic [CW-1:0]   hmod,
    output logic [4*CW-1:0] wide
);
    localparam int NW = 2 * CW;

    logic [NW-1:0] nib_raw;
    logic [NW-1:0] nib_mask;
    logic [NW-1:0] nib_mod;

    // Build the widened value, the mask and the modified nibble.
    always_comb begin
        nib_raw  = {code, code};
        nib_mask = '0;
        nib_mask[NW-2:1] = hmod;
        nib_mod  = nib_raw ^ nib_mask;
        wide     = {nib_mod, nib_mod};
    end
endmodule

// File: rtl/hrgb_unpack_stage.sv
// Module: hrgb_unpack_stage
// First pipeline stage. It splits the packed byte into fields, widens
// every colour field with the shared modifier mask, and registers the
// three channel bytes together with the valid flag.
// Assumes a synchronous active-low reset. The registered channels change
// only on a valid input.
module hrgb_unpack_stage
    import hrgb_pkg::*;
#(
    parameter int CW = CH_W,
    parameter int NC = NUM_CH
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [(NC+1)*CW-1:0]   in_pixel,
    output logic                   s1_valid,
    output logic [NC-1:0][4*CW-1:0] s1_chan
);
    localparam int BW = 4 * CW;

    logic [CW-1:0]          hmod;
    logic [NC-1:0][BW-1:0]  chan_d;

    // Pick out the modifier field from the top of the byte.
    always_comb hmod = in_pixel[(NC+1)*CW-1 -: CW];

    for (genvar gi = 0; gi < NC; gi++) begin : g_chan
        hrgb_chan_widen #(.CW(CW)) u_widen (
            .code (in_pixel[gi*CW +: CW]),
            .hmod (hmod),
            .wide (chan_d[gi])
        );
    end

    // Register the valid flag; reset empties the stage.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_valid <= 1'b0;
        else        s1_valid <= in_valid;
    end

    // Register channel bytes only for valid pixels.
    always_ff @(posedge clk) begin
        if (!rst_n)        s1_chan <= '0;
        else if (in_valid) s1_chan <= chan_d;
    end

    AST_S1_VALID_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (s1_valid == $past(in_valid)));                     // R6
    AST_S1_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable(s1_chan));            // R8
    AST_S1_NIBBLE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> (s1_chan[IDX_R][BW-1:BW/2] == s1_chan[IDX_R][BW/2-1:0]
                   && s1_chan[IDX_G][BW-1:BW/2] == s1_chan[IDX_G][BW/2-1:0]
                   && s1_chan[IDX_B][BW-1:BW/2] == s1_chan[IDX_B][BW/2-1:0])); // R3
endmodule

// File: rtl/hrgb_order_stage.sv
// Module: hrgb_order_stage
// Second pipeline stage. It places the three channel bytes into the
// output word in the order chosen by the static mode input, and registers
// the word and the valid flag.
// Assumes order_bgr is constant while pixels are in flight. The word
// changes only when a valid pixel arrives from the first stage.
module hrgb_order_stage
    import hrgb_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int NC = NUM_CH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 order_bgr,
    input  logic                 s1_valid,
    input  logic [NC-1:0][BW-1:0] s1_chan,
    output logic                 out_valid,
    output logic [NC*BW-1:0]     out_rgb
);
    logic [NC*BW-1:0] word_d;

    // Arrange the bytes: green in the middle, red and blue swap by mode.
    always_comb begin
        if (order_bgr) word_d = {s1_chan[IDX_R], s1_chan[IDX_G], s1_chan[IDX_B]};
        else           word_d = {s1_chan[IDX_B], s1_chan[IDX_G], s1_chan[IDX_R]};
    end

    // Register the valid flag; reset empties the stage.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= s1_valid;
    end

    // Register the output word only for valid pixels.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_rgb <= '0;
        else if (s1_valid) out_rgb <= word_d;
    end

    AST_S2_VALID_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(s1_valid)));                    // R6
    AST_OUT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !out_valid) |-> $stable(out_rgb));                  // R8
    AST_RGB_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid && !order_bgr && $stable(order_bgr)) |->
        (out_rgb[BW-1:0] == $past(s1_chan[IDX_R])
         && out_rgb[2*BW-1:BW] == $past(s1_chan[IDX_G])
         && out_rgb[3*BW-1:2*BW] == $past(s1_chan[IDX_B])));                 // R4
    AST_BGR_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid && order_bgr && $stable(order_bgr)) |->
        (out_rgb[BW-1:0] == $past(s1_chan[IDX_B])
         && out_rgb[2*BW-1:BW] == $past(s1_chan[IDX_G])
         && out_rgb[3*BW-1:2*BW] == $past(s1_chan[IDX_R])));                 // R5
endmodule

// File: rtl/hrgb_expand_top.sv
// Module: hrgb_expand_top
// Two-stage pipelined converter from a packed modifier/colour byte to a
// 24-bit colour word. Stage one widens the fields; stage two orders and
// registers the bytes.
// Assumes order_bgr is static while the pipeline holds pixels. The
// latency is fixed at two clocks.
module hrgb_expand_top
    import hrgb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_pixel,
    input  logic              order_bgr,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_rgb
);
    logic      s1_valid;
    chan_set_t s1_chan;

    hrgb_unpack_stage #(.CW(CH_W), .NC(NUM_CH)) u_unpack (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_pixel (in_pixel),
        .s1_valid (s1_valid),
        .s1_chan  (s1_chan)
    );

    hrgb_order_stage #(.BW(BYTE_W), .NC(NUM_CH)) u_order (
        .clk       (clk),
        .rst_n     (rst_n),
        .order_bgr (order_bgr),
        .s1_valid  (s1_valid),
        .s1_chan   (s1_chan),
        .out_valid (out_valid),
        .out_rgb   (out_rgb)
    );
endmodule

// File: tb/hrgb_expand_top_tb.sv
module hrgb_expand_top_tb;
    localparam time CYC = 4ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_pixel = 8'h00;
    logic        order_bgr = 1'b0;
    logic        out_valid;
    logic [23:0] out_rgb;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic        hv [2];
    logic [7:0]  hp [2];
    logic [23:0] last_out;

    always #(CYC/2) clk = ~clk;

    hrgb_expand_top u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pixel(in_pixel),
        .order_bgr(order_bgr), .out_valid(out_valid), .out_rgb(out_rgb)
    );

    // Reference: field to byte, following R1, R2 and R3.
    function automatic logic [7:0] ref_chan(input logic [1:0] c, input logic [1:0] h);
        logic [3:0] n;
        n = {c[1], c[0], c[1], c[0]} ^ {1'b0, h[1], h[0], 1'b0};
        return {n, n};
    endfunction

    // Reference word for one pixel under an order mode (R4, R5).
    function automatic logic [23:0] ref_word(input logic [7:0] p, input logic bgr);
        logic [7:0] r, g, b;
        r = ref_chan(p[5:4], p[7:6]);
        g = ref_chan(p[3:2], p[7:6]);
        b = ref_chan(p[1:0], p[7:6]);
        return bgr ? {r, g, b} : {b, g, r};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %06h expected %06h", tag, act, exp);
        end
    endtask

    task automatic clear_hist();
        hv[0] = 1'b0; hv[1] = 1'b0; hp[0] = '0; hp[1] = '0;
        last_out = '0;
    endtask

    // Compare outputs against the pixel driven two steps earlier.
    task automatic check_outputs();
        check(out_valid == hv[1], "R6 valid delay", {23'd0, out_valid}, {23'd0, hv[1]});
        if (hv[1]) begin
            logic [23:0] e;
            string t;
            e = ref_word(hp[1], order_bgr);
            t = order_bgr ? "R5" : "R4";
            t = {t, (hp[1][7:6] == 2'b00) ? " R1 R3 data" : " R2 R3 data"};
            check(out_rgb == e, t, out_rgb, e);
            last_out = out_rgb;
        end else begin
            check(out_rgb == last_out, "R8 idle hold", out_rgb, last_out);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] p);
        @(negedge clk);
        check_outputs();
        in_valid = v;
        in_pixel = p;
        hv[1] = hv[0]; hp[1] = hp[0];
        hv[0] = v;     hp[0] = p;
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) step(1'b0, 8'($urandom));
    endtask

    // Direct literal check of one pixel through the bench's own view (R9).
    task automatic directed(input logic [7:0] p, input logic bgr, input logic [23:0] lit);
        flush();
        order_bgr = bgr;
        step(1'b1, p);
        flush();
        check(last_out == lit, "R9 literal", last_out, lit);
    endtask

    task automatic apply_reset(input int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        for (int i = 0; i < cycles; i++) @(negedge clk);
        // R7: valid and word cleared
        check(out_valid == 1'b0, "R7 reset valid", {23'd0, out_valid}, 24'd0);
        check(out_rgb == 24'd0, "R7 reset data", out_rgb, 24'd0);
        rst_n = 1'b1;
        clear_hist();
    endtask

    initial begin
        void'($urandom(32'd20250611));
        clear_hist();
        apply_reset(4);

        // Full sweep in both orders, back to back (R1..R5 via model)
        for (int m = 0; m < 2; m++) begin
            flush();
            order_bgr = m[0];
            for (int k = 0; k < 256; k++) step(1'b1, 8'(k));
        end

        // Directed corners (R9, R4, R5)
        directed(8'h00, 1'b0, 24'h000000);
        directed(8'h15, 1'b0, 24'h555555);
        directed(8'h2A, 1'b1, 24'hAAAAAA);
        directed(8'h3F, 1'b0, 24'hFFFFFF);
        directed(8'hFF, 1'b1, 24'h999999);
        directed(8'hC0, 1'b0, 24'h666666);
        directed(8'h30, 1'b0, 24'h0000FF);   // red only, R4 placement
        directed(8'h30, 1'b1, 24'hFF0000);   // red only, R5 placement
        directed(8'h43, 1'b0, 24'hDD2222);   // modifier 01, blue 3

        // Random stream with idle gaps; idle bytes must not leak (R8)
        for (int blk = 0; blk < 12; blk++) begin
            flush();
            order_bgr = 1'($urandom);
            for (int i = 0; i < 250; i++)
                step(($urandom % 4) != 0, 8'($urandom));
        end

        // Reset in mid-stream (R7)
        for (int i = 0; i < 5; i++) step(1'b1, 8'($urandom));
        apply_reset(1);
        for (int i = 0; i < 40; i++) step(1'($urandom), 8'($urandom));
        flush();

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(CYC * 100000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule